// File: doc/BRIEF.md
# Multi-Mode 12-bit Timer/Counter

This block is a 12-bit up-counter that one set of registers shares among four uses: a periodic interval timer, a counter of external events, a meter for the width of a high pulse on an input pin, and a square-wave generator. In timer, width and square modes it advances on a prescaled tick that comes in from outside. In event mode it advances on rising edges of the external pin. Each time it wraps past its top value it reloads a programmed value and raises an interrupt request.

The external pin first passes through a level qualifier clocked by the instruction-cycle strobe. Any high or low level shorter than two strobe samples is dropped. Software sets the reload value, the mode, a run bit and an immediate-load bit through a small write port, and clears the interrupt flag through the same port. A wake pulse from the low-power controller puts the counter back at its fixed start value, as reset does.

Top module: `tmr12_unit`

## Requirements
- R1: After reset the count is 0xFF0, the interrupt flag is 0, the square output is 0, the capture value is 0, and the counter is stopped in interval mode with a reload value of 0.
- R2: In interval mode (control bits [1:0] = 0) with run set (control bit 2), the count rises by one on each cycle in which tick_i is high. With run clear, the count holds.
- R3: When the count is 0xFFF and an increment occurs, the count takes the reload value (register address 0) and irq_o goes to 1.
- R4: Writing 1 to bit 0 at address 2 clears irq_o. If an overflow occurs in the same cycle, the flag stays set.
- R5: The filtered input changes level only after two consecutive cyc_i samples of ext_i at the new level. A level held for one sample has no effect, and ext_i is not sampled while cyc_i is low.
- R6: In event mode (mode 1) the count rises by one for each qualified rising edge of ext_i, and tick_i has no effect.
- R7: In width mode (mode 2), a qualified rising edge clears the count. The count then advances on tick_i while the qualified input is high. The qualified falling edge copies the count to cap_o, and counting stops.
- R8: sq_o toggles on every overflow in square mode (mode 3). In any other mode sq_o holds.
- R9: A wake_i pulse sets the count to 0xFF0 and leaves mode, run, reload and the interrupt flag unchanged.
- R10: A control write (address 1) with bit 3 set loads the reload value into the count in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Prescaled internal count tick |
| cyc_i | input | 1 | Instruction-cycle strobe that samples ext_i |
| ext_i | input | 1 | External event / pulse input pin |
| wake_i | input | 1 | Exit from low-power hold, restores start value |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 reload, 1 control, 2 flag clear |
| wr_data | input | 12 | Write data |
| count_o | output | 12 | Current count |
| cap_o | output | 12 | Width captured on falling edge |
| irq_o | output | 1 | Overflow interrupt request |
| sq_o | output | 1 | Square-wave output |

## Verification
The hardest case to reach is a clear of the interrupt flag in the very cycle in which the counter wraps. The stimulus gets there by loading a reload value just below the top through the immediate-load bit. It then steps the counter to 0xFFF with one tick and drives the next tick together with the clear write. Pulse-width capture also needs exact alignment of the two-stage qualifier with the tick stream, so the bench holds the input high for a known number of strobes and checks that the captured width is one less than that number.

// File: rtl/tmr12_pkg.sv
package tmr12_pkg;

    typedef enum logic [1:0] {
        MD_INTERVAL = 2'd0,
        MD_EVENT    = 2'd1,
        MD_WIDTH    = 2'd2,
        MD_SQUARE   = 2'd3
    } tmr_mode_e;

    typedef struct packed {
        tmr_mode_e mode;
        logic      run;
    } tmr_cfg_t;

    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } qual_t;

    localparam logic [1:0] A_RELOAD = 2'd0;
    localparam logic [1:0] A_CTRL   = 2'd1;
    localparam logic [1:0] A_CLEAR  = 2'd2;

    localparam int B_RUN  = 2;
    localparam int B_LOAD = 3;

    function automatic logic at_top(input logic [11:0] v);
        return &v;
    endfunction

endpackage

// File: rtl/tmr12_regs.sv
module tmr12_regs
    import tmr12_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [CW-1:0] wr_data,
    output logic [CW-1:0] reload_q,
    output tmr_cfg_t      cfg_q,
    output logic          load_p,
    output logic          clr_p
);
    logic ctrl_wr;

    assign ctrl_wr = wr_en && (wr_addr == A_CTRL);
    assign load_p  = ctrl_wr && wr_data[B_LOAD];
    assign clr_p   = wr_en && (wr_addr == A_CLEAR) && wr_data[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q   <= '0;
            cfg_q.mode <= MD_INTERVAL;
            cfg_q.run  <= 1'b0;
        end else begin
            if (wr_en && (wr_addr == A_RELOAD))
                reload_q <= wr_data;
            if (ctrl_wr) begin
                cfg_q.mode <= tmr_mode_e'(wr_data[1:0]);
                cfg_q.run  <= wr_data[B_RUN];
            end
        end
    end
endmodule

// File: rtl/tmr12_qual.sv
module tmr12_qual
    import tmr12_pkg::*;
#(
    parameter int QUAL = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  cyc_i,
    input  logic  ext_i,
    output qual_t q_o
);
    localparam int QW = (QUAL > 1) ? $clog2(QUAL) : 1;
    localparam logic [QW-1:0] LAST = QW'(QUAL - 1);

    logic [QW-1:0] run_q;
    logic          differs;

    assign differs = cyc_i && (ext_i != q_o.level);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
            q_o   <= '0;
        end else begin
            q_o.rise <= 1'b0;
            q_o.fall <= 1'b0;
            if (cyc_i) begin
                if (!differs) begin
                    run_q <= '0;
                end else if (run_q == LAST) begin
                    run_q     <= '0;
                    q_o.level <= ext_i;
                    q_o.rise  <= ext_i;
                    q_o.fall  <= !ext_i;
                end else begin
                    run_q <= run_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/tmr12_core.sv
module tmr12_core
    import tmr12_pkg::*;
#(
    parameter int            CW       = 12,
    parameter logic [CW-1:0] INIT_VAL = 12'hFF0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_i,
    input  logic          wake_i,
    input  qual_t         q_i,
    input  tmr_cfg_t      cfg_i,
    input  logic [CW-1:0] reload_i,
    input  logic          load_p,
    input  logic          clr_p,
    output logic [CW-1:0] count_o,
    output logic [CW-1:0] cap_o,
    output logic          irq_o,
    output logic          sq_o
);
    logic src, step, restart, preempt, wrap;

    always_comb begin
        unique case (cfg_i.mode)
            MD_EVENT: src = q_i.rise;
            MD_WIDTH: src = tick_i && q_i.level;
            default:  src = tick_i;
        endcase
    end

    assign step    = cfg_i.run && src;
    assign restart = cfg_i.run && (cfg_i.mode == MD_WIDTH) && q_i.rise;
    assign preempt = wake_i || load_p || restart;
    assign wrap    = step && !preempt && (&count_o);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_o <= INIT_VAL;
            cap_o   <= '0;
            irq_o   <= 1'b0;
            sq_o    <= 1'b0;
        end else begin
            if (wake_i)
                count_o <= INIT_VAL;
            else if (load_p)
                count_o <= reload_i;
            else if (restart)
                count_o <= '0;
            else if (step)
                count_o <= wrap ? reload_i : count_o + 1'b1;

            if (wrap)
                irq_o <= 1'b1;
            else if (clr_p)
                irq_o <= 1'b0;

            if (wrap && (cfg_i.mode == MD_SQUARE))
                sq_o <= !sq_o;

            if (cfg_i.run && (cfg_i.mode == MD_WIDTH) && q_i.fall)
                cap_o <= count_o;
        end
    end
endmodule

// File: rtl/tmr12_unit.sv
module tmr12_unit
    import tmr12_pkg::*;
#(
    parameter int            CW       = 12,
    parameter int            QUAL     = 2,
    parameter logic [CW-1:0] INIT_VAL = 12'hFF0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_i,
    input  logic          cyc_i,
    input  logic          ext_i,
    input  logic          wake_i,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [CW-1:0] wr_data,
    output logic [CW-1:0] count_o,
    output logic [CW-1:0] cap_o,
    output logic          irq_o,
    output logic          sq_o
);
    logic [CW-1:0] reload_q;
    tmr_cfg_t      cfg_q;
    qual_t         qual;
    logic          load_p, clr_p;

    tmr12_regs #(.CW(CW)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .reload_q(reload_q), .cfg_q(cfg_q),
        .load_p(load_p), .clr_p(clr_p)
    );

    tmr12_qual #(.QUAL(QUAL)) u_qual (
        .clk(clk), .rst(rst), .cyc_i(cyc_i), .ext_i(ext_i), .q_o(qual)
    );

    tmr12_core #(.CW(CW), .INIT_VAL(INIT_VAL)) u_core (
        .clk(clk), .rst(rst), .tick_i(tick_i), .wake_i(wake_i),
        .q_i(qual), .cfg_i(cfg_q), .reload_i(reload_q),
        .load_p(load_p), .clr_p(clr_p), .count_o(count_o),
        .cap_o(cap_o), .irq_o(irq_o), .sq_o(sq_o)
    );
endmodule

// File: rtl/tmr12_chk.sv
module tmr12_chk #(
    parameter int            CW       = 12,
    parameter logic [CW-1:0] INIT_VAL = 12'hFF0
) (
    input logic          clk,
    input logic          rst,
    input logic          cyc_i,
    input logic          wake_i,
    input logic          wr_en,
    input logic [1:0]    wr_addr,
    input logic [CW-1:0] wr_data,
    input logic [CW-1:0] count_o,
    input logic [CW-1:0] cap_o,
    input logic          irq_o,
    input logic          sq_o,
    input logic [CW-1:0] reload_q,
    input logic [1:0]    mode_q,
    input logic          run_q,
    input logic          level_q
);
    // R2
    stopped_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run_q && !wr_en && !wake_i) |=> $stable(count_o));

    // R3
    wrap_reload_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(irq_o) && !$past(wr_en)) |-> (count_o == reload_q));

    // R5
    strobe_only_chk: assert property (@(posedge clk) disable iff (rst)
        !cyc_i |=> $stable(level_q));

    // R7
    cap_width_only_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q != 2'd2) |=> $stable(cap_o));

    // R8
    sq_square_only_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q != 2'd3) |=> $stable(sq_o));

    // R9
    wake_init_chk: assert property (@(posedge clk) disable iff (rst)
        wake_i |=> (count_o == INIT_VAL));

    // R10
    load_now_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 2'd1 && wr_data[3] && !wake_i)
        |=> (count_o == $past(reload_q)));
endmodule

bind tmr12_unit tmr12_chk #(.CW(CW), .INIT_VAL(INIT_VAL)) u_chk (
    .clk(clk), .rst(rst), .cyc_i(cyc_i), .wake_i(wake_i),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .count_o(count_o), .cap_o(cap_o), .irq_o(irq_o), .sq_o(sq_o),
    .reload_q(reload_q), .mode_q(cfg_q.mode), .run_q(cfg_q.run),
    .level_q(qual.level)
);

// File: tb/tmr12_unit_test.sv
`timescale 1ns/1ps
module tmr12_unit_test;
    localparam int QUAL = 2;
    localparam int INIT = 'hFF0;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_i = 0, cyc_i = 0, ext_i = 0, wake_i = 0, wr_en = 0;
    logic [1:0]  wr_addr = 0;
    logic [11:0] wr_data = 0;
    logic [11:0] count_o, cap_o;
    logic        irq_o, sq_o;

    int total = 0, bad = 0;
    bit done = 0, armed = 0;

    always #2 clk = ~clk;

    tmr12_unit uut (
        .clk(clk), .rst(rst), .tick_i(tick_i), .cyc_i(cyc_i), .ext_i(ext_i),
        .wake_i(wake_i), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .count_o(count_o), .cap_o(cap_o), .irq_o(irq_o), .sq_o(sq_o)
    );

    // behavioural reference
    int m_cnt, m_reload, m_mode, m_cap;
    bit m_run, m_flag, m_sq, m_lvl, m_rise, m_fall;
    bit b_load, b_clr, b_go, b_ovf;
    int hist[$];

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = INIT; m_reload = 0; m_mode = 0; m_cap = 0;
            m_run = 0; m_flag = 0; m_sq = 0; m_lvl = 0; m_rise = 0; m_fall = 0;
            hist.delete();
        end else begin
            b_load = wr_en && wr_addr == 1 && wr_data[3];
            b_clr  = wr_en && wr_addr == 2 && wr_data[0];
            b_ovf  = 0;
            case (m_mode)
                1: b_go = m_rise;
                2: b_go = tick_i && m_lvl;
                default: b_go = tick_i;
            endcase
            b_go = b_go && m_run;
            if (m_run && m_mode == 2 && m_fall) m_cap = m_cnt;
            if (wake_i) m_cnt = INIT;
            else if (b_load) m_cnt = m_reload;
            else if (m_run && m_mode == 2 && m_rise) m_cnt = 0;
            else if (b_go) begin
                if (m_cnt == 4095) begin m_cnt = m_reload; b_ovf = 1; end
                else m_cnt = m_cnt + 1;
            end
            if (b_ovf) m_flag = 1; else if (b_clr) m_flag = 0;
            if (b_ovf && m_mode == 3) m_sq = !m_sq;
            if (wr_en && wr_addr == 0) m_reload = int'(wr_data);
            if (wr_en && wr_addr == 1) begin
                m_mode = int'(wr_data[1:0]); m_run = wr_data[2];
            end
            m_rise = 0; m_fall = 0;
            if (cyc_i) begin
                if (ext_i == m_lvl) hist.delete();
                else begin
                    hist.push_back(int'(ext_i));
                    if (hist.size() >= QUAL) begin
                        m_lvl = ext_i;
                        if (ext_i) m_rise = 1; else m_fall = 1;
                        hist.delete();
                    end
                end
            end
        end
    end

    always @(negedge clk) begin
        if (armed && !rst && !done) begin
            total += 4;
            if (int'(count_o) != m_cnt) begin bad++;
                $display("FAIL R2 count actual=%h expected=%h", count_o, m_cnt); end
            if (irq_o != m_flag) begin bad++;
                $display("FAIL R3 irq actual=%0d expected=%0d", irq_o, m_flag); end
            if (sq_o != m_sq) begin bad++;
                $display("FAIL R8 sq actual=%0d expected=%0d", sq_o, m_sq); end
            if (int'(cap_o) != m_cap) begin bad++;
                $display("FAIL R7 cap actual=%h expected=%h", cap_o, m_cap); end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [11:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic ticks(input int n);
        tick_i = 1;
        repeat (n) @(negedge clk);
        tick_i = 0;
    endtask

    task automatic hold_ext(input logic v, input int n);
        ext_i = v;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        armed = 1;
        // R1 reset values
        chk("R1 count", int'(count_o), 'hFF0);
        chk("R1 irq", int'(irq_o), 0);
        chk("R1 sq", int'(sq_o), 0);
        chk("R1 cap", int'(cap_o), 0);
        ticks(5);
        chk("R2 stopped", int'(count_o), 'hFF0);

        wr(2'd0, 12'h123);
        wr(2'd1, 12'h004);
        ticks(15);
        chk("R2 interval", int'(count_o), 'hFFF);
        chk("R3 no flag yet", int'(irq_o), 0);
        ticks(1);
        chk("R3 wrap reload", int'(count_o), 'h123);
        chk("R3 flag", int'(irq_o), 1);

        wr(2'd2, 12'h001);
        chk("R4 clear", int'(irq_o), 0);
        wr(2'd0, 12'hFFE);
        wr(2'd1, 12'h00C);
        chk("R10 load", int'(count_o), 'hFFE);
        ticks(1);
        tick_i = 1; wr(2'd2, 12'h001); tick_i = 0;
        chk("R4 set wins", int'(irq_o), 1);
        chk("R3 reload again", int'(count_o), 'hFFE);

        wr(2'd2, 12'h001);
        wr(2'd1, 12'h007);
        ticks(2);
        chk("R8 toggle high", int'(sq_o), 1);
        ticks(2);
        chk("R8 toggle low", int'(sq_o), 0);
        wr(2'd1, 12'h004);
        ticks(2);
        chk("R8 interval no toggle", int'(sq_o), 0);

        wr(2'd0, 12'h010);
        wr(2'd1, 12'h00D);
        cyc_i = 1; tick_i = 1;
        hold_ext(1, 1);
        hold_ext(0, 3);
        chk("R5 glitch ignored", int'(count_o), 'h010);
        hold_ext(1, 4);
        chk("R6 event edge", int'(count_o), 'h011);
        hold_ext(0, 4);
        cyc_i = 0;
        hold_ext(1, 4);
        chk("R5 no strobe", int'(count_o), 'h011);
        cyc_i = 1;
        hold_ext(0, 3);
        hold_ext(1, 4);
        chk("R6 second edge", int'(count_o), 'h012);
        hold_ext(0, 4);

        wr(2'd1, 12'h006);
        hold_ext(1, 10);
        hold_ext(0, 5);
        chk("R7 captured width", int'(cap_o), 9);
        chk("R7 stopped after fall", int'(count_o), 9);

        tick_i = 0;
        wr(2'd1, 12'h004);
        wake_i = 1; @(negedge clk); wake_i = 0;
        chk("R9 wake value", int'(count_o), 'hFF0);
        chk("R9 flag kept", int'(irq_o), 1);
        ticks(1);
        chk("R9 config kept", int'(count_o), 'hFF1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule